// File: doc/BRIEF.md
# Ordered Interrupt Message Packetizer

This block sits on the device side of a packetized upstream link. Ordinary posted writes enter it as a dword stream and wait in a queue. When the device raises an interrupt, the block turns the event into a posted write packet. The packet is aimed at the reserved interrupt address window and carries the vector, the interrupt type and an end-of-interrupt request flag. Platform bits from two configuration inputs fill the rest of the interrupt information.

The interrupt packet is three dwords long: two control dwords and one data dword. It leaves only after every posted write dword that was queued before the event has been sent. A posted packet that is already leaving is never split by an interrupt. Posted writes that arrive after the event wait behind the interrupt packet.

A second event that arrives while one interrupt is waiting goes into a single holding slot. A busy flag tells the source when that slot is full. An event that arrives with the end-of-interrupt type code is refused.

Top module: `msi_pkt_gen`

## Requirements
- R1: After reset, out_valid and irq_busy are low and pw_ready is high.
- R2: Interrupt control dword 0 has [5:0]=6'b101000, [9:6]=0 (one data dword follows), [15:10]=0, [23:16]=vector and [31:24]=cfg_info_b2.
- R3: Interrupt control dword 1 has [1:0]=0, [4:2]=type, [5]=EOI-request flag, [15:6]=0, [23:16]=ADDR_MID (default 8'hF8) and [31:24]=ADDR_HI (default 8'hFD). out_last is low on both control dwords.
- R4: The interrupt data dword is {8'h00, cfg_info_hi} and is sent with out_last high.
- R5: Every posted write dword accepted in a cycle before the interrupt strobe leaves before control dword 0 of that interrupt.
- R6: A posted packet is never split by an interrupt. Posted packets whose first dword is accepted after the strobe leave after the interrupt data dword.
- R7: A strobe with type 3'b111 produces no packet and does not take a slot.
- R8: A strobe that arrives while an interrupt is pending is stored, and irq_busy goes high. The stored interrupt is sent right after the pending one, and irq_busy then falls.
- R9: A strobe that arrives while irq_busy is high is dropped.
- R10: While out_valid is high and out_ready is low, out_valid, out_dw and out_last hold their values.
- R11: Posted write dwords leave unchanged and in order, and each keeps its pw_last flag on out_last.
- R12: pw_ready is low while the queue holds PW_DEPTH dwords.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| pw_valid | input | 1 | Posted write dword valid |
| pw_ready | output | 1 | Queue can accept a dword |
| pw_dw | input | 32 | Posted write dword |
| pw_last | input | 1 | Last dword of a posted packet |
| irq_strobe | input | 1 | Interrupt event, one cycle |
| irq_vector | input | 8 | Interrupt vector |
| irq_type | input | 3 | Interrupt type code |
| irq_eoi_req | input | 1 | Ask for an end-of-interrupt return |
| irq_busy | output | 1 | Holding slot is full |
| cfg_info_b2 | input | 8 | Information bits [23:16] |
| cfg_info_hi | input | 24 | Information bits [55:32] |
| out_valid | output | 1 | Output dword valid |
| out_ready | input | 1 | Downstream accepts the dword |
| out_dw | output | 32 | Output dword |
| out_last | output | 1 | Last dword of the packet |

## Verification
The bench builds the block with PW_DEPTH=4 and leaves HOLD_EN and the address bytes at their defaults. A queue this shallow can be filled with a few writes, so the bench reaches the full-queue stall on pw_ready. It can also set the fence depth at an event and drain it under backpressure. With the holding slot enabled, the bench reaches the pending-plus-held case and the dropped third strobe. The mid-packet case is forced by sending the first dword of a posted packet before the strobe and its last dword after it.

// File: rtl/msi_pkg.sv
package msi_pkg;

   localparam logic [5:0] CMD_POSTED_BYTE_WR = 6'b101000;
   localparam logic [2:0] KIND_EOI           = 3'b111;
   localparam int         IRQ_DWORDS         = 3;

   typedef struct packed {
      logic [7:0] vec;
      logic [2:0] kind;
      logic       eoi;
   } irq_evt_t;

   function automatic logic [31:0] irq_dword(
      input logic [1:0]  idx,
      input irq_evt_t    evt,
      input logic [7:0]  info_b2,
      input logic [23:0] info_hi,
      input logic [7:0]  addr_hi,
      input logic [7:0]  addr_mid
   );
      logic [31:0] d;
      case (idx)
         2'd0:    d = {info_b2, evt.vec, 6'h00, 4'h0, CMD_POSTED_BYTE_WR};
         2'd1:    d = {addr_hi, addr_mid, 8'h00, 2'b00, evt.eoi, evt.kind, 2'b00};
         default: d = {8'h00, info_hi};
      endcase
      return d;
   endfunction

endpackage

// File: rtl/msi_pw_fifo.sv
module msi_pw_fifo #(
   parameter int DEPTH = 8,
   parameter int WIDTH = 33,
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   output logic             in_ready,
   input  logic [WIDTH-1:0] in_data,
   output logic             out_valid,
   input  logic             out_ready,
   output logic [WIDTH-1:0] out_data,
   output logic [CW-1:0]    occ
);

   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW-1:0]    wr_ptr;
   logic [AW-1:0]    rd_ptr;
   logic             push;
   logic             pop;

   assign in_ready  = (occ != CW'(DEPTH));
   assign out_valid = (occ != '0);
   assign out_data  = mem[rd_ptr];
   assign push      = in_valid && in_ready;
   assign pop       = out_valid && out_ready;

   function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
      return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
   endfunction

   always_ff @(posedge clk) begin
      if (push) mem[wr_ptr] <= in_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         occ    <= '0;
      end else begin
         if (push) wr_ptr <= bump(wr_ptr);
         if (pop)  rd_ptr <= bump(rd_ptr);
         case ({push, pop})
            2'b10:   occ <= occ + 1'b1;
            2'b01:   occ <= occ - 1'b1;
            default: occ <= occ;
         endcase
      end
   end

endmodule

// File: rtl/msi_irq_slots.sv
module msi_irq_slots
   import msi_pkg::*;
#(
   parameter int CW      = 4,
   parameter bit HOLD_EN = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          evt_strobe,
   input  irq_evt_t      evt_in,
   input  logic [CW-1:0] occ,
   input  logic          pop,
   input  logic          retire,
   output logic          act_v,
   output irq_evt_t      act_evt,
   output logic          act_fence_zero,
   output logic          busy
);

   logic          evt_ok;
   logic [CW-1:0] fence_new;
   logic [CW-1:0] act_f;
   logic [CW-1:0] act_f_n;

   function automatic logic [CW-1:0] drain(input logic [CW-1:0] f, input logic p);
      return (p && f != '0) ? f - 1'b1 : f;
   endfunction

   assign evt_ok         = evt_strobe && (evt_in.kind != KIND_EOI);
   assign fence_new      = pop ? occ - 1'b1 : occ;
   assign act_f_n        = drain(act_f, pop);
   assign act_fence_zero = (act_f == '0);

   generate
      if (HOLD_EN) begin : g_hold
         logic          hold_v;
         irq_evt_t      hold_evt;
         logic [CW-1:0] hold_f;

         assign busy = hold_v;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               act_v    <= 1'b0;
               act_evt  <= '0;
               act_f    <= '0;
               hold_v   <= 1'b0;
               hold_evt <= '0;
               hold_f   <= '0;
            end else if (retire) begin
               hold_v <= 1'b0;
               if (hold_v) begin
                  act_v   <= 1'b1;
                  act_evt <= hold_evt;
                  act_f   <= drain(hold_f, pop);
               end else if (evt_ok) begin
                  act_v   <= 1'b1;
                  act_evt <= evt_in;
                  act_f   <= fence_new;
               end else begin
                  act_v <= 1'b0;
               end
            end else begin
               act_f  <= act_f_n;
               hold_f <= drain(hold_f, pop);
               if (evt_ok && !act_v) begin
                  act_v   <= 1'b1;
                  act_evt <= evt_in;
                  act_f   <= fence_new;
               end else if (evt_ok && !hold_v) begin
                  hold_v   <= 1'b1;
                  hold_evt <= evt_in;
                  hold_f   <= fence_new;
               end
            end
         end
      end else begin : g_single
         assign busy = act_v;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               act_v   <= 1'b0;
               act_evt <= '0;
               act_f   <= '0;
            end else if (retire) begin
               act_v <= 1'b0;
            end else begin
               act_f <= act_f_n;
               if (evt_ok && !act_v) begin
                  act_v   <= 1'b1;
                  act_evt <= evt_in;
                  act_f   <= fence_new;
               end
            end
         end
      end
   endgenerate

endmodule

// File: rtl/msi_out_arb.sv
module msi_out_arb
   import msi_pkg::*;
#(
   parameter logic [7:0] ADDR_HI  = 8'hFD,
   parameter logic [7:0] ADDR_MID = 8'hF8
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        fifo_valid,
   input  logic [32:0] fifo_data,
   output logic        fifo_pop,
   input  logic        act_v,
   input  logic        act_fence_zero,
   input  irq_evt_t    act_evt,
   input  logic [7:0]  cfg_info_b2,
   input  logic [23:0] cfg_info_hi,
   output logic        out_valid,
   input  logic        out_ready,
   output logic [31:0] out_dw,
   output logic        out_last,
   output logic        retire,
   output logic        sel_irq,
   output logic [1:0]  irq_idx
);

   localparam logic [1:0] LAST_IDX = 2'(IRQ_DWORDS - 1);

   logic in_pw;
   logic fire;

   assign sel_irq   = (irq_idx != 2'd0) || (!in_pw && act_v && act_fence_zero);
   assign out_valid = sel_irq || fifo_valid;
   assign out_dw    = sel_irq
                      ? irq_dword(irq_idx, act_evt, cfg_info_b2, cfg_info_hi, ADDR_HI, ADDR_MID)
                      : fifo_data[31:0];
   assign out_last  = sel_irq ? (irq_idx == LAST_IDX) : fifo_data[32];
   assign fire      = out_valid && out_ready;
   assign fifo_pop  = fire && !sel_irq;
   assign retire    = fire && sel_irq && (irq_idx == LAST_IDX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_idx <= 2'd0;
         in_pw   <= 1'b0;
      end else begin
         if (fire && sel_irq)
            irq_idx <= (irq_idx == LAST_IDX) ? 2'd0 : irq_idx + 2'd1;
         if (fifo_pop)
            in_pw <= !fifo_data[32];
      end
   end

endmodule

// File: rtl/msi_pkt_gen.sv
module msi_pkt_gen
   import msi_pkg::*;
#(
   parameter int         PW_DEPTH = 8,
   parameter bit         HOLD_EN  = 1'b1,
   parameter logic [7:0] ADDR_HI  = 8'hFD,
   parameter logic [7:0] ADDR_MID = 8'hF8
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        pw_valid,
   output logic        pw_ready,
   input  logic [31:0] pw_dw,
   input  logic        pw_last,
   input  logic        irq_strobe,
   input  logic [7:0]  irq_vector,
   input  logic [2:0]  irq_type,
   input  logic        irq_eoi_req,
   output logic        irq_busy,
   input  logic [7:0]  cfg_info_b2,
   input  logic [23:0] cfg_info_hi,
   output logic        out_valid,
   input  logic        out_ready,
   output logic [31:0] out_dw,
   output logic        out_last
);

   localparam int CW = $clog2(PW_DEPTH + 1);

   generate
      if (PW_DEPTH < 2) begin : g_bad_depth
         $error("PW_DEPTH must be at least 2");
      end
   endgenerate

   logic          fifo_valid;
   logic [32:0]   fifo_data;
   logic          fifo_pop;
   logic [CW-1:0] occ;
   logic          act_v;
   logic          act_fence_zero;
   irq_evt_t      act_evt;
   irq_evt_t      evt_in;
   logic          retire;
   logic          sel_irq;
   logic [1:0]    irq_idx;

   assign evt_in = '{vec: irq_vector, kind: irq_type, eoi: irq_eoi_req};

   msi_pw_fifo #(.DEPTH(PW_DEPTH), .WIDTH(33)) u_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (pw_valid),
      .in_ready  (pw_ready),
      .in_data   ({pw_last, pw_dw}),
      .out_valid (fifo_valid),
      .out_ready (fifo_pop),
      .out_data  (fifo_data),
      .occ       (occ)
   );

   msi_irq_slots #(.CW(CW), .HOLD_EN(HOLD_EN)) u_slots (
      .clk            (clk),
      .rst_n          (rst_n),
      .evt_strobe     (irq_strobe),
      .evt_in         (evt_in),
      .occ            (occ),
      .pop            (fifo_pop),
      .retire         (retire),
      .act_v          (act_v),
      .act_evt        (act_evt),
      .act_fence_zero (act_fence_zero),
      .busy           (irq_busy)
   );

   msi_out_arb #(.ADDR_HI(ADDR_HI), .ADDR_MID(ADDR_MID)) u_arb (
      .clk            (clk),
      .rst_n          (rst_n),
      .fifo_valid     (fifo_valid),
      .fifo_data      (fifo_data),
      .fifo_pop       (fifo_pop),
      .act_v          (act_v),
      .act_fence_zero (act_fence_zero),
      .act_evt        (act_evt),
      .cfg_info_b2    (cfg_info_b2),
      .cfg_info_hi    (cfg_info_hi),
      .out_valid      (out_valid),
      .out_ready      (out_ready),
      .out_dw         (out_dw),
      .out_last       (out_last),
      .retire         (retire),
      .sel_irq        (sel_irq),
      .irq_idx        (irq_idx)
   );

endmodule

// File: rtl/msi_pkt_gen_chk.sv
module msi_pkt_gen_chk #(
   parameter int PW_DEPTH = 8,
   parameter bit HOLD_EN  = 1'b1,
   localparam int CW = $clog2(PW_DEPTH + 1)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          out_valid,
   input logic          out_ready,
   input logic [31:0]   out_dw,
   input logic          out_last,
   input logic          irq_strobe,
   input logic [2:0]    irq_type,
   input logic          irq_busy,
   input logic [CW-1:0] occ,
   input logic          act_v,
   input logic          retire,
   input logic          sel_irq,
   input logic [1:0]    irq_idx
);

   // R12: the queue never holds more dwords than it has room for
   a_r12_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      occ <= CW'(PW_DEPTH));

   // R10: a stalled output holds still
   a_r10_stall_stable: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_dw) && $stable(out_last));

   // R7: the reserved type code never reaches control dword 1
   a_r7_no_eoi_kind: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_ready && sel_irq && irq_idx == 2'd1 |-> out_dw[4:2] != 3'b111);

   // R8: a second event while one is pending fills the holding slot
   a_r8_second_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
      HOLD_EN && irq_strobe && irq_type != 3'b111 && act_v && !retire && !irq_busy
      |=> irq_busy);

   // R9: a dropped strobe does not release the busy flag
   a_r9_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
      irq_busy && !retire |=> irq_busy);

endmodule

bind msi_pkt_gen msi_pkt_gen_chk #(.PW_DEPTH(PW_DEPTH), .HOLD_EN(HOLD_EN)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .out_valid  (out_valid),
   .out_ready  (out_ready),
   .out_dw     (out_dw),
   .out_last   (out_last),
   .irq_strobe (irq_strobe),
   .irq_type   (irq_type),
   .irq_busy   (irq_busy),
   .occ        (occ),
   .act_v      (act_v),
   .retire     (retire),
   .sel_irq    (sel_irq),
   .irq_idx    (irq_idx)
);

// File: tb/tb_msi_pkt_gen.sv
`timescale 1ns/1ps
module tb_msi_pkt_gen;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        pw_valid;
   logic        pw_ready;
   logic [31:0] pw_dw;
   logic        pw_last;
   logic        irq_strobe;
   logic [7:0]  irq_vector;
   logic [2:0]  irq_type;
   logic        irq_eoi_req;
   logic        irq_busy;
   logic [7:0]  cfg_info_b2;
   logic [23:0] cfg_info_hi;
   logic        out_valid;
   logic        out_ready;
   logic [31:0] out_dw;
   logic        out_last;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   logic [32:0] log_q [0:63];
   int          nlog = 0;

   always #4 clk = ~clk;

   msi_pkt_gen #(.PW_DEPTH(4)) dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .pw_valid    (pw_valid),
      .pw_ready    (pw_ready),
      .pw_dw       (pw_dw),
      .pw_last     (pw_last),
      .irq_strobe  (irq_strobe),
      .irq_vector  (irq_vector),
      .irq_type    (irq_type),
      .irq_eoi_req (irq_eoi_req),
      .irq_busy    (irq_busy),
      .cfg_info_b2 (cfg_info_b2),
      .cfg_info_hi (cfg_info_hi),
      .out_valid   (out_valid),
      .out_ready   (out_ready),
      .out_dw      (out_dw),
      .out_last    (out_last)
   );

   always @(negedge clk) begin
      if (rst_n && out_valid && out_ready && nlog < 64) begin
         log_q[nlog] = {out_last, out_dw};
         nlog++;
      end
   end

   task automatic chk(input string req, input logic [32:0] act, input logic [32:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [32:0] exp_irq(input int i, input logic [7:0] vec,
                                           input logic [2:0] kind, input logic eoi,
                                           input logic [7:0] b2, input logic [23:0] hi);
      if (i == 0) return {1'b0, b2, vec, 6'h00, 4'h0, 6'b101000};
      if (i == 1) return {1'b0, 8'hFD, 8'hF8, 8'h00, 2'b00, eoi, kind, 2'b00};
      return {1'b1, 8'h00, hi};
   endfunction

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic push(input logic [31:0] d, input logic l);
      bit ok;
      pw_valid = 1'b1; pw_dw = d; pw_last = l;
      do begin
         @(negedge clk); ok = pw_ready;
         @(posedge clk); #1;
      end while (!ok);
      pw_valid = 1'b0;
   endtask

   task automatic strobe(input logic [7:0] v, input logic [2:0] k, input logic e);
      irq_strobe = 1'b1; irq_vector = v; irq_type = k; irq_eoi_req = e;
      step(1);
      irq_strobe = 1'b0;
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk("R1 out_valid", {32'h0, out_valid}, 33'h0);
      chk("R1 irq_busy", {32'h0, irq_busy}, 33'h0);
      chk("R1 pw_ready", {32'h0, pw_ready}, 33'h1);
   endtask

   task automatic t_basic();
      int s = nlog;
      cfg_info_b2 = 8'h3C; cfg_info_hi = 24'hABCDEF; out_ready = 1'b1;
      strobe(8'h5A, 3'b010, 1'b1);
      step(10);
      chk("R2 count", nlog - s, 3);
      chk("R2 dword0", log_q[s],   exp_irq(0, 8'h5A, 3'b010, 1'b1, 8'h3C, 24'hABCDEF));
      chk("R3 dword1", log_q[s+1], exp_irq(1, 8'h5A, 3'b010, 1'b1, 8'h3C, 24'hABCDEF));
      chk("R4 data",   log_q[s+2], exp_irq(2, 8'h5A, 3'b010, 1'b1, 8'h3C, 24'hABCDEF));
   endtask

   task automatic t_order();
      int s = nlog;
      out_ready = 1'b0;
      push(32'h0000_0011, 1'b0);
      push(32'h0000_0012, 1'b1);
      strobe(8'h21, 3'b001, 1'b0);
      push(32'h0000_0021, 1'b1);
      out_ready = 1'b1;
      step(15);
      chk("R5 count", nlog - s, 6);
      chk("R5 first write",  log_q[s],   {1'b0, 32'h11});
      chk("R11 last flag",   log_q[s+1], {1'b1, 32'h12});
      chk("R5 irq after writes", log_q[s+2], exp_irq(0, 8'h21, 3'b001, 1'b0, 8'h3C, 24'hABCDEF));
      chk("R4 data", log_q[s+4], exp_irq(2, 8'h21, 3'b001, 1'b0, 8'h3C, 24'hABCDEF));
      chk("R6 later write after irq", log_q[s+5], {1'b1, 32'h21});
   endtask

   task automatic t_midpkt();
      int s = nlog;
      out_ready = 1'b1;
      push(32'h0000_0031, 1'b0);
      step(2);
      strobe(8'h44, 3'b000, 1'b0);
      step(2);
      chk("R6 irq waits mid-packet", nlog - s, 1);
      push(32'h0000_0032, 1'b1);
      step(10);
      chk("R6 count", nlog - s, 5);
      chk("R6 packet closes first", log_q[s+1], {1'b1, 32'h32});
      chk("R6 irq follows", log_q[s+2], exp_irq(0, 8'h44, 3'b000, 1'b0, 8'h3C, 24'hABCDEF));
   endtask

   task automatic t_reserved();
      int s = nlog;
      out_ready = 1'b1;
      strobe(8'h66, 3'b111, 1'b1);
      step(10);
      chk("R7 no packet", nlog - s, 0);
      chk("R7 no slot", {32'h0, irq_busy}, 33'h0);
      strobe(8'h77, 3'b011, 1'b0);
      step(10);
      chk("R7 next irq sent", log_q[s], exp_irq(0, 8'h77, 3'b011, 1'b0, 8'h3C, 24'hABCDEF));
   endtask

   task automatic t_hold();
      int s = nlog;
      out_ready = 1'b0;
      strobe(8'h01, 3'b001, 1'b0);
      strobe(8'h02, 3'b010, 1'b1);
      @(negedge clk);
      chk("R8 busy on second", {32'h0, irq_busy}, 33'h1);
      step(1);
      strobe(8'h03, 3'b011, 1'b0);
      out_ready = 1'b1;
      step(15);
      chk("R9 third dropped", nlog - s, 6);
      chk("R8 first irq", log_q[s],   exp_irq(0, 8'h01, 3'b001, 1'b0, 8'h3C, 24'hABCDEF));
      chk("R8 held irq",  log_q[s+3], exp_irq(0, 8'h02, 3'b010, 1'b1, 8'h3C, 24'hABCDEF));
      chk("R8 held type", log_q[s+4], exp_irq(1, 8'h02, 3'b010, 1'b1, 8'h3C, 24'hABCDEF));
      chk("R8 busy clears", {32'h0, irq_busy}, 33'h0);
   endtask

   task automatic t_stall_full();
      int s = nlog;
      logic [31:0] a;
      out_ready = 1'b0;
      push(32'hCAFE_0001, 1'b0);
      push(32'hCAFE_0002, 1'b0);
      push(32'hCAFE_0003, 1'b0);
      push(32'hCAFE_0004, 1'b1);
      @(negedge clk);
      chk("R12 full", {32'h0, pw_ready}, 33'h0);
      a = out_dw;
      step(3);
      @(negedge clk);
      chk("R10 held dword", {out_valid, out_dw}, {1'b1, a});
      chk("R10 head value", {1'b0, a}, {1'b0, 32'hCAFE_0001});
      for (int i = 0; i < 16; i++) begin
         out_ready = i[0];
         step(1);
      end
      out_ready = 1'b1;
      step(5);
      chk("R11 count", nlog - s, 4);
      for (int i = 0; i < 4; i++)
         chk("R11 order", log_q[s+i], {i == 3, 32'hCAFE_0001 + 32'(i)});
   endtask

   initial begin
      rst_n = 1'b0; pw_valid = 1'b0; pw_dw = '0; pw_last = 1'b0;
      irq_strobe = 1'b0; irq_vector = '0; irq_type = '0; irq_eoi_req = 1'b0;
      cfg_info_b2 = '0; cfg_info_hi = '0; out_ready = 1'b0;
      step(3);
      rst_n = 1'b1;
      t_reset();
      t_basic();
      t_order();
      t_midpkt();
      t_reserved();
      t_hold();
      t_stall_full();
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule